// File: doc/BRIEF.md
# Output Voltage Window Supervisor

This block watches the regulated output of a step-down converter through three feedback comparator flags. The flags report feedback above the overvoltage level, below the undervoltage level, and below the low discharge-release level. The block turns those flags into protection decisions and into the power-good indication.

Overvoltage protection is armed as soon as the converter is enabled and both supplies are valid. An overvoltage trip forces the high-side switch off and drives the low-side switch as a hysteretic discharger. Undervoltage protection is masked until soft-start completes; once it trips, it requests a soft-off with both switches off. Both voltage faults stay latched until enable or a supply is cycled.

Power-good rises only after soft-start and while feedback sits inside the regulation window. Any latched fault, or any externally reported protection such as overcurrent or overtemperature, pulls it low. Every comparator flag is first synchronised and then deglitched by a digital filter whose length is configurable.

Top module: `vout_window_supervisor`

## Requirements
- R1: A comparator flag takes effect only after a two-flop synchroniser and FILT_LEN consecutive equal samples. A high pulse shorter than FILT_LEN cycles has no effect on any output.
- R2: The filtered overvoltage flag latches `ov_fault` whenever the block is armed. Armed means `en`, `vcc_ok` and `vin_ok` are all high. Soft-start state has no bearing on this. A feedback node held high from enable, as a floating node would be, therefore trips.
- R3: `hs_force_off` is high in every cycle in which either voltage fault is latched. It rises in the same cycle as the fault.
- R4: On an overvoltage trip, `ls_force_on` rises together with `ov_fault`. While `ov_fault` is latched, `ls_force_on` falls once the filtered discharge-release flag is high. It rises again once the filtered overvoltage flag is high again. `ov_fault` stays high throughout.
- R5: The filtered undervoltage flag latches `uv_fault` only while the block is armed and `ss_done` is high. `soft_off_req` follows `uv_fault`.
- R6: Both faults clear in the cycle after the block stops being armed. While the block stays armed, they never clear.
- R7: `pgood` is registered. It is high one cycle after a cycle in which all of the following hold: the block is armed, `ss_done` is high, neither filtered window flag is set, no fault is latched, and `ext_fault` is all zero.
- R8: `ls_force_off` is high when `seq_ls_off` is high or `uv_fault` is latched, except while `ls_force_on` is high. The discharge request always wins.
- R9: While `rst_n` is low, all outputs are low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable, already synchronous |
| vcc_ok | input | 1 | Signal supply above lockout |
| vin_ok | input | 1 | Power supply above lockout |
| ss_done | input | 1 | Soft-start ramp finished |
| ov_cmp | input | 1 | Asynchronous flag: feedback above overvoltage level |
| uv_cmp | input | 1 | Asynchronous flag: feedback below undervoltage level |
| dis_cmp | input | 1 | Asynchronous flag: feedback below discharge-release level |
| ext_fault | input | NUM_EXT | Other active protections, such as overcurrent and overtemperature |
| seq_ls_off | input | 1 | Sequencer request to hold the low-side switch off |
| ov_fault | output | 1 | Latched overvoltage fault |
| uv_fault | output | 1 | Latched undervoltage fault |
| hs_force_off | output | 1 | Force the high-side switch off |
| ls_force_on | output | 1 | Force the low-side switch on for discharge |
| ls_force_off | output | 1 | Force the low-side switch off |
| soft_off_req | output | 1 | Request for the soft-off sequence |
| pgood | output | 1 | Power-good, high when in regulation |

## Verification
Two functions can fall in the same cycle. The hysteretic discharger may re-assert `ls_force_on` in a cycle where the sequencer is still asking for the low-side switch to be held off. The bench holds `seq_ls_off` high through a full discharge toggle and expects `ls_force_off` to drop in exactly the cycles where `ls_force_on` rises. A second case: an external fault is released in the same cycle that the filtered window flags return to normal. Here `pgood` must recover one cycle later and not before. A behavioural model predicts every output on every clock, so a collision that resolves in the wrong cycle shows up as a mismatch at that edge.

// File: rtl/vsup_pkg.sv
// Shared constants for the output voltage window supervisor.
// Assumes three comparator channels, in a fixed order.
package vsup_pkg;
    localparam int CH_OV  = 0;   // feedback above overvoltage level
    localparam int CH_UV  = 1;   // feedback below undervoltage level
    localparam int CH_DIS = 2;   // feedback below discharge-release level
    localparam int NUM_CH = 3;
endpackage

// File: rtl/vsup_flag_cond.sv
// Conditions one asynchronous comparator flag.
// A two-flop synchroniser is followed by a deglitcher. The output
// takes a new value only after FILT_LEN consecutive synchronised
// samples that differ from it.
// Assumes FILT_LEN >= 1. The output resets low (flag inactive).
module vsup_flag_cond #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_LEN - 1);

    logic          meta_q, sync_q;
    logic [CW-1:0] cnt_q;

    // Bring the raw flag into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    // Count disagreeing samples; flip the output once enough in a row are seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_o <= 1'b0;
        end else if (sync_q == filt_o) begin
            cnt_q <= '0;
        end else if (cnt_q == LIM) begin
            cnt_q  <= '0;
            filt_o <= sync_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> ($past(sync_q) == filt_o));
endmodule

// File: rtl/vsup_fault_core.sv
// Fault latches and the hysteretic low-side discharger.
// Assumes filtered flags as inputs. `armed` combines enable and
// both supply-valid conditions; when it drops, all state clears.
module vsup_fault_core (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic ss_done,
    input  logic ov_f,
    input  logic uv_f,
    input  logic dis_f,
    output logic ov_fault,
    output logic uv_fault,
    output logic ls_dis
);
    // Latch the overvoltage fault; it clears only when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) ov_fault <= 1'b0;
        else if (ov_f)        ov_fault <= 1'b1;
    end

    // Latch the undervoltage fault, which is masked before soft-start ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)      uv_fault <= 1'b0;
        else if (ss_done && uv_f)  uv_fault <= 1'b1;
    end

    // Discharger: on at an overvoltage, off at the release level, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)            ls_dis <= 1'b0;
        else if (ov_fault || ov_f) begin
            if (ov_f)                    ls_dis <= 1'b1;
            else if (dis_f)              ls_dis <= 1'b0;
        end else                         ls_dis <= 1'b0;
    end

    // R6
    ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_fault && armed) |=> ov_fault);
    // R5
    uv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_fault) |-> $past(ss_done && armed));
    // R4
    dis_needs_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_dis |-> ov_fault);
endmodule

// File: rtl/vout_window_supervisor.sv
// Top of the output voltage window supervisor.
// Conditions the three comparator flags and runs the fault core.
// Derives the switch overrides and registers power-good.
// Assumes en/vcc_ok/vin_ok/ss_done/ext_fault/seq_ls_off are synchronous.
module vout_window_supervisor
    import vsup_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int NUM_EXT  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               vcc_ok,
    input  logic               vin_ok,
    input  logic               ss_done,
    input  logic               ov_cmp,
    input  logic               uv_cmp,
    input  logic               dis_cmp,
    input  logic [NUM_EXT-1:0] ext_fault,
    input  logic               seq_ls_off,
    output logic               ov_fault,
    output logic               uv_fault,
    output logic               hs_force_off,
    output logic               ls_force_on,
    output logic               ls_force_off,
    output logic               soft_off_req,
    output logic               pgood
);
    logic [NUM_CH-1:0] raw, filt;
    logic              armed, ls_dis, pg_cond;

    assign raw[CH_OV]  = ov_cmp;
    assign raw[CH_UV]  = uv_cmp;
    assign raw[CH_DIS] = dis_cmp;
    assign armed       = en && vcc_ok && vin_ok;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cond
        vsup_flag_cond #(.FILT_LEN(FILT_LEN)) u_cond (
            .clk(clk), .rst_n(rst_n), .raw_i(raw[c]), .filt_o(filt[c])
        );
    end

    vsup_fault_core u_core (
        .clk(clk), .rst_n(rst_n), .armed(armed), .ss_done(ss_done),
        .ov_f(filt[CH_OV]), .uv_f(filt[CH_UV]), .dis_f(filt[CH_DIS]),
        .ov_fault(ov_fault), .uv_fault(uv_fault), .ls_dis(ls_dis)
    );

    // Overrides: the discharge request outranks every low-side-off request.
    always_comb begin
        hs_force_off = ov_fault || uv_fault;
        ls_force_on  = ls_dis;
        ls_force_off = (seq_ls_off || uv_fault) && !ls_dis;
        soft_off_req = uv_fault;
    end

    assign pg_cond = armed && ss_done && !filt[CH_OV] && !filt[CH_UV]
                   && !ov_fault && !uv_fault && (ext_fault == '0);

    // Register power-good from the window and protection state.
    always_ff @(posedge clk) begin
        if (!rst_n) pgood <= 1'b0;
        else        pgood <= pg_cond;
    end

    // R8
    ls_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_force_on && ls_force_off));
    // R3
    hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_fault || uv_fault) |-> hs_force_off);
    // R7
    pgood_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(armed && ss_done));
    // R7
    pgood_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ov_fault || uv_fault) |-> !pgood);
endmodule

// File: tb/tb_vout_window_supervisor.sv
module tb_vout_window_supervisor;
    localparam int FL = 4;
    localparam int NE = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 0, vcc_ok = 0, vin_ok = 0, ss_done = 0;
    logic ov_cmp = 0, uv_cmp = 0, dis_cmp = 0, seq_ls_off = 0;
    logic [NE-1:0] ext_fault = '0;
    logic ov_fault, uv_fault, hs_force_off, ls_force_on, ls_force_off, soft_off_req, pgood;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vout_window_supervisor #(.FILT_LEN(FL), .NUM_EXT(NE)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .vcc_ok(vcc_ok), .vin_ok(vin_ok),
        .ss_done(ss_done), .ov_cmp(ov_cmp), .uv_cmp(uv_cmp), .dis_cmp(dis_cmp),
        .ext_fault(ext_fault), .seq_ls_off(seq_ls_off),
        .ov_fault(ov_fault), .uv_fault(uv_fault), .hs_force_off(hs_force_off),
        .ls_force_on(ls_force_on), .ls_force_off(ls_force_off),
        .soft_off_req(soft_off_req), .pgood(pgood));

    // Behavioural reference: pipelines as integer arrays, then the latches.
    int s1[3], s2[3], cnt[3], f[3];
    int m_ov = 0, m_uv = 0, m_ls = 0, m_pg = 0;

    initial for (int c = 0; c < 3; c++) begin s1[c] = 0; s2[c] = 0; cnt[c] = 0; f[c] = 0; end

    always @(posedge clk) begin
        int raw[3];
        int armed, n_ov, n_uv, n_ls, n_pg;
        raw[0] = ov_cmp; raw[1] = uv_cmp; raw[2] = dis_cmp;
        armed = en && vcc_ok && vin_ok;
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin s1[c] = 0; s2[c] = 0; cnt[c] = 0; f[c] = 0; end
            m_ov = 0; m_uv = 0; m_ls = 0; m_pg = 0;
        end else begin
            n_pg = armed && ss_done && !f[0] && !f[1] && !m_ov && !m_uv && (ext_fault == 0);
            if (!armed) begin n_ov = 0; n_uv = 0; n_ls = 0; end
            else begin
                n_ov = m_ov || f[0];
                n_uv = m_uv || (ss_done && f[1]);
                if (m_ov || f[0]) n_ls = f[0] ? 1 : (f[2] ? 0 : m_ls);
                else n_ls = 0;
            end
            m_ov = n_ov; m_uv = n_uv; m_ls = n_ls; m_pg = n_pg;
            for (int c = 0; c < 3; c++) begin
                if (s2[c] == f[c]) cnt[c] = 0;
                else if (cnt[c] == FL - 1) begin f[c] = s2[c]; cnt[c] = 0; end
                else cnt[c]++;
                s2[c] = s1[c]; s1[c] = raw[c];
            end
        end
    end

    task automatic chk(input logic act, input int exp, input string req);
        checks++;
        if (act !== exp[0]) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0b expected=%0d", req, $time, act, exp);
        end
    endtask

    // Compare every output against the model on every cycle.
    always @(negedge clk) if (cyc > 0 && !done) begin
        chk(ov_fault,     m_ov,                        "R2 ov_fault");
        chk(hs_force_off, m_ov || m_uv,                "R3 hs_force_off");
        chk(ls_force_on,  m_ls,                        "R4 ls_force_on");
        chk(uv_fault,     m_uv,                        "R5 uv_fault");
        chk(soft_off_req, m_uv,                        "R5 soft_off_req");
        chk(pgood,        m_pg,                        "R7 pgood");
        chk(ls_force_off, (seq_ls_off || m_uv) && !m_ls, "R8 ls_force_off");
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        // R9 reset state
        chk(ov_fault, 0, "R9 reset"); chk(pgood, 0, "R9 reset"); chk(ls_force_on, 0, "R9 reset");
        rst_n = 1;
        en = 1; vcc_ok = 1; vin_ok = 1; wait_n(10);
        chk(pgood, 0, "R7 before soft-start");
        ss_done = 1; wait_n(4);
        chk(pgood, 1, "R7 in window");
        // R1 short glitches ignored
        ov_cmp = 1; wait_n(FL - 1); ov_cmp = 0; wait_n(12);
        chk(ov_fault, 0, "R1 ov glitch"); chk(pgood, 1, "R1 ov glitch");
        uv_cmp = 1; wait_n(FL - 1); uv_cmp = 0; wait_n(12);
        chk(uv_fault, 0, "R1 uv glitch");
        // R7 external protection, released as window recovers
        ext_fault = 2'b10; wait_n(3); chk(pgood, 0, "R7 ext fault");
        ext_fault = 2'b00; wait_n(2); chk(pgood, 1, "R7 ext release");
        // R4 overvoltage trip and hysteretic discharge under a sequencer off request
        seq_ls_off = 1; ov_cmp = 1; wait_n(FL + 4);
        chk(ov_fault, 1, "R2 trip"); chk(ls_force_on, 1, "R4 discharge on");
        chk(ls_force_off, 0, "R8 priority");
        ov_cmp = 0; dis_cmp = 1; wait_n(FL + 4);
        chk(ls_force_on, 0, "R4 release"); chk(ov_fault, 1, "R4 latched");
        dis_cmp = 0; ov_cmp = 1; wait_n(FL + 4);
        chk(ls_force_on, 1, "R4 re-on");
        ov_cmp = 0; seq_ls_off = 0; wait_n(10);
        chk(ov_fault, 1, "R6 held");
        // R6 cycling enable clears
        en = 0; wait_n(2); chk(ov_fault, 0, "R6 clear"); chk(hs_force_off, 0, "R6 clear");
        // R5 undervoltage masked during soft-start
        ss_done = 0; en = 1; uv_cmp = 1; wait_n(12);
        chk(uv_fault, 0, "R5 masked");
        ss_done = 1; wait_n(2);
        chk(uv_fault, 1, "R5 trip"); chk(soft_off_req, 1, "R5 soft-off");
        chk(ls_force_off, 1, "R8 soft-off ls");
        vin_ok = 0; uv_cmp = 0; wait_n(2); chk(uv_fault, 0, "R6 supply cycle");
        // R2 floating feedback held high from enable
        vin_ok = 1; ss_done = 0; ov_cmp = 1; wait_n(FL + 4);
        chk(ov_fault, 1, "R2 floating");
        ov_cmp = 0; wait_n(8);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule